// File: doc/BRIEF.md
# AUX-channel I2C EDID responder

This block stands in for a display AUX channel controller, but only for one job: letting software fetch a monitor's EDID through I2C-over-AUX requests. Software writes a request header into the first data word, then writes the control register with the send bit set. The block answers at once. It decodes the header and updates its I2C session (start, restart, stop, target select). It sets the control register to "done" with a reply size, and rewrites the first data word with the I2C acknowledge code. For a read, that word also carries the next EDID byte.

The EDID contents sit outside the block. The block shows its current read pointer on `edid_rd_addr` and takes the addressed byte back on `edid_rd_data` in the same cycle. One input per display port tells whether a DisplayPort monitor is attached. `chan_port` names the port this channel serves. Register reads go through a separate combinational read port.

Top module: `aux_edid_responder`

## Requirements
- R1: A write to offset 0x14, 0x18, 0x1C, 0x20 or 0x24 (low address byte) stores the full 32-bit value in data word 1 to 5. That word reads back unchanged on the read port. A write to any other offset except 0x10 is dropped, and those offsets read as 0.
- R2: A write to the control offset 0x10 with bit 31 clear changes nothing: control and all data words keep their values.
- R3: A write to 0x10 with bit 31 (send) set makes the control register read 0x4000_0000 plus a reply size in bits 24:20. The size is 2 when the header's read bit (data word 1 bit 28) is 1, and 1 otherwise.
- R4: The request length is taken from bits 24:20 of the send write. The header address is data word 1 bits 23:8, and the middle-of-transaction flag is bit 30. A length-3 request with that flag clear is a stop: the session is cleared (target deselected, EDID unavailable, read pointer 0).
- R5: A length-3 request with the middle-of-transaction flag set and address 0 clears the session in the same way as a stop.
- R6: A length-3 request with the middle-of-transaction flag set and address 0x50 selects the EDID target. EDID becomes available only if `dp_present[chan_port]` is 1 at that moment. A restart of this kind keeps the read pointer. Other addresses leave the session untouched.
- R7: After every send other than a malformed read (R11), data word 1 holds the acknowledge code 0x00 in bits 31:24. For address-only and write requests the whole word is 0x0000_0000, so write data is discarded.
- R8: A read request (header bit 28 = 1) of length 4, with the target selected and EDID available, returns the EDID byte at the read pointer in bits 23:16 of data word 1. All other bits are 0, and the pointer advances by one.
- R9: A length-4 read while the target is not selected or EDID is unavailable returns 0xFF in bits 23:16 (word 0x00FF_0000). The pointer does not move.
- R10: Once the read pointer reaches 128, a length-4 read returns the byte value 0 and the pointer stays at 128.
- R11: A read request with a length other than 3 or 4 still updates the control register as in R3, but leaves data word 1 and the session unchanged.
- R12: After reset the control register and all data words read 0 and the session is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset, low byte decoded |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read offset, low byte decoded |
| rd_data | output | 32 | Combinational read data |
| chan_port | input | 2 | Index of the display port this channel serves |
| dp_present | input | 4 | Per-port DisplayPort monitor present flags |
| edid_rd_addr | output | 7 | EDID store address (read pointer) |
| edid_rd_data | input | 8 | EDID byte at `edid_rd_addr` |

## Verification
The register read port and the reply write-back can meet in one cycle. A read of data word 1 can coincide with the send that overwrites it. The bench provokes this by holding `rd_addr` at 0x14 while the send strobe is active. In that cycle it expects the old request header, and after the edge it expects the reply word. Random sequences of starts, stops, reads, malformed reads, ignored control writes and monitor-presence changes are judged against a bench-side model of the session. A directed run drives the read pointer past the 128-byte end.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

   // register offsets (low address byte)
   localparam logic [7:0] OFS_CTRL      = 8'h10;
   localparam int unsigned OFS_DATA_BASE = 32'h14;
   localparam int unsigned OFS_STRIDE    = 4;

   // control register fields
   localparam int unsigned CTL_SEND_BIT = 31;
   localparam int unsigned CTL_DONE_BIT = 30;
   localparam int unsigned CTL_SIZE_LSB = 20;
   localparam int unsigned CTL_SIZE_W   = 5;

   // request command nibble fields (nibble sits in header bits 31:28)
   localparam int unsigned CMD_READ_BIT = 0;
   localparam int unsigned CMD_MOT_BIT  = 2;

   localparam logic [7:0] I2C_ACK_CODE = 8'h00;
   localparam logic [7:0] NO_DATA_BYTE = 8'hFF;

   localparam logic [CTL_SIZE_W-1:0] LEN_ADDR_ONLY = 5'd3;
   localparam logic [CTL_SIZE_W-1:0] LEN_READ      = 5'd4;

   typedef struct packed {
      logic [3:0]  cmd;
      logic [3:0]  ctl_lo;
      logic [15:0] addr;
      logic [7:0]  low;
   } aux_hdr_t;

   typedef enum logic [1:0] {
      REQ_ADDR_ONLY,
      REQ_WRITE,
      REQ_READ,
      REQ_BAD_READ
   } req_kind_e;

endpackage

// File: rtl/aux_reg_decode.sv
module aux_reg_decode #(
   parameter int unsigned NUM_DATA = 5
) (
   input  logic [7:0]          ofs,
   output logic                is_ctrl,
   output logic [NUM_DATA-1:0] data_hit
);
   import aux_edid_pkg::*;

   assign is_ctrl = (ofs == OFS_CTRL);

   for (genvar g = 0; g < NUM_DATA; g++) begin : g_data_dec
      localparam logic [7:0] OFS_G = 8'(OFS_DATA_BASE + OFS_STRIDE * g);
      assign data_hit[g] = (ofs == OFS_G);
   end

endmodule

// File: rtl/aux_session.sv
module aux_session #(
   parameter int unsigned PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             pick,
   input  logic             pick_avail,
   input  logic             adv,
   output logic             sess_sel,
   output logic             sess_avail,
   output logic [PTR_W-1:0] ptr
);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sess_sel   <= 1'b0;
         sess_avail <= 1'b0;
         ptr        <= '0;
      end else begin
         if (pick) begin
            sess_sel   <= 1'b1;
            sess_avail <= pick_avail;
         end
         if (adv) begin
            ptr <= ptr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/aux_reply_build.sv
module aux_reply_build #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned EDID_BYTES  = 128,
   parameter int unsigned PTR_W       = 8,
   parameter logic [15:0] EDID_TARGET = 16'h0050
) (
   input  logic              send,
   input  logic [4:0]        req_len,
   input  logic [DATA_W-1:0] hdr_word,
   input  logic              sess_sel,
   input  logic              sess_avail,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [7:0]        edid_byte,
   output logic [DATA_W-1:0] ctrl_next,
   output logic [DATA_W-1:0] data_next,
   output logic              data_load,
   output logic              sess_clr,
   output logic              sess_pick,
   output logic              ptr_adv
);
   import aux_edid_pkg::*;

   localparam logic [PTR_W-1:0] PTR_END = PTR_W'(EDID_BYTES);

   aux_hdr_t  hdr;
   logic      is_rd;
   logic      is_mot;
   req_kind_e kind;
   logic [7:0] rd_byte;

   assign hdr    = aux_hdr_t'(hdr_word);
   assign is_rd  = hdr.cmd[CMD_READ_BIT];
   assign is_mot = hdr.cmd[CMD_MOT_BIT];

   always_comb begin
      if (req_len == LEN_ADDR_ONLY) kind = REQ_ADDR_ONLY;
      else if (!is_rd)              kind = REQ_WRITE;
      else if (req_len == LEN_READ) kind = REQ_READ;
      else                          kind = REQ_BAD_READ;
   end

   always_comb begin
      rd_byte = NO_DATA_BYTE;
      ptr_adv = 1'b0;
      if (sess_sel && sess_avail) begin
         if (ptr < PTR_END) begin
            rd_byte = edid_byte;
            ptr_adv = send && (kind == REQ_READ);
         end else begin
            rd_byte = 8'h00;
         end
      end
   end

   always_comb begin
      ctrl_next = '0;
      data_next = '0;
      data_load = 1'b0;
      sess_clr  = 1'b0;
      sess_pick = 1'b0;
      if (send) begin
         ctrl_next[CTL_DONE_BIT] = 1'b1;
         ctrl_next[CTL_SIZE_LSB +: CTL_SIZE_W] = is_rd ? 5'd2 : 5'd1;
         data_load = 1'b1;
         data_next[DATA_W-1 -: 8] = I2C_ACK_CODE;
         unique case (kind)
            REQ_ADDR_ONLY: begin
               if (!is_mot || hdr.addr == 16'h0000) sess_clr  = 1'b1;
               else if (hdr.addr == EDID_TARGET)    sess_pick = 1'b1;
            end
            REQ_WRITE: begin
            end
            REQ_READ: begin
               data_next[23:16] = rd_byte;
            end
            REQ_BAD_READ: begin
               data_load = 1'b0;
            end
            default: begin
            end
         endcase
      end
   end

endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_DATA    = 5,
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned EDID_BYTES  = 128,
   parameter logic [15:0] EDID_TARGET = 16'h0050,
   localparam int unsigned PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int unsigned EDID_AW    = $clog2(EDID_BYTES),
   localparam int unsigned PTR_W      = EDID_AW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   input  logic [PORT_W-1:0]    chan_port,
   input  logic [NUM_PORTS-1:0] dp_present,
   output logic [EDID_AW-1:0]   edid_rd_addr,
   input  logic [7:0]           edid_rd_data
);
   import aux_edid_pkg::*;

   // elaboration checks
   if (DATA_W != 32) begin : g_bad_width
      $error("aux_edid_responder: header layout needs DATA_W == 32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("aux_edid_responder: ADDR_W must cover the low offset byte");
   end
   if (NUM_DATA < 2 || NUM_DATA > 59) begin : g_bad_ndata
      $error("aux_edid_responder: NUM_DATA out of range");
   end
   if ((1 << EDID_AW) != EDID_BYTES) begin : g_bad_edid
      $error("aux_edid_responder: EDID_BYTES must be a power of two");
   end

   logic                wr_is_ctrl;
   logic [NUM_DATA-1:0] wr_hit;
   logic                rd_is_ctrl;
   logic [NUM_DATA-1:0] rd_hit;

   aux_reg_decode #(.NUM_DATA(NUM_DATA)) u_wr_dec (
      .ofs      (wr_addr[7:0]),
      .is_ctrl  (wr_is_ctrl),
      .data_hit (wr_hit)
   );

   aux_reg_decode #(.NUM_DATA(NUM_DATA)) u_rd_dec (
      .ofs      (rd_addr[7:0]),
      .is_ctrl  (rd_is_ctrl),
      .data_hit (rd_hit)
   );

   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] data_q [NUM_DATA];

   logic              send;
   logic [DATA_W-1:0] ctrl_next;
   logic [DATA_W-1:0] data_next;
   logic              data_load;
   logic              sess_clr;
   logic              sess_pick;
   logic              ptr_adv;
   logic              sess_sel;
   logic              sess_avail;
   logic [PTR_W-1:0]  edid_ptr;
   logic              port_present;

   assign send = wr_en && wr_is_ctrl && wr_data[CTL_SEND_BIT];

   // presence lookup: guard only when the index can exceed the port count
   if (NUM_PORTS == (1 << PORT_W)) begin : g_present_full
      assign port_present = dp_present[chan_port];
   end else begin : g_present_guard
      assign port_present = (32'(chan_port) < NUM_PORTS) ? dp_present[chan_port] : 1'b0;
   end

   aux_reply_build #(
      .DATA_W      (DATA_W),
      .EDID_BYTES  (EDID_BYTES),
      .PTR_W       (PTR_W),
      .EDID_TARGET (EDID_TARGET)
   ) u_reply (
      .send       (send),
      .req_len    (wr_data[CTL_SIZE_LSB +: CTL_SIZE_W]),
      .hdr_word   (data_q[0]),
      .sess_sel   (sess_sel),
      .sess_avail (sess_avail),
      .ptr        (edid_ptr),
      .edid_byte  (edid_rd_data),
      .ctrl_next  (ctrl_next),
      .data_next  (data_next),
      .data_load  (data_load),
      .sess_clr   (sess_clr),
      .sess_pick  (sess_pick),
      .ptr_adv    (ptr_adv)
   );

   aux_session #(.PTR_W(PTR_W)) u_sess (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (sess_clr),
      .pick       (sess_pick),
      .pick_avail (port_present),
      .adv        (ptr_adv),
      .sess_sel   (sess_sel),
      .sess_avail (sess_avail),
      .ptr        (edid_ptr)
   );

   assign edid_rd_addr = edid_ptr[EDID_AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (send)  ctrl_q <= ctrl_next;
   end

   // data word 0 also takes the reply; a send never hits a data offset
   always_ff @(posedge clk) begin
      if (!rst_n)                    data_q[0] <= '0;
      else if (wr_en && wr_hit[0])   data_q[0] <= wr_data;
      else if (data_load)            data_q[0] <= data_next;
   end

   for (genvar g = 1; g < NUM_DATA; g++) begin : g_data_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                  data_q[g] <= '0;
         else if (wr_en && wr_hit[g]) data_q[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_is_ctrl) rd_data = ctrl_q;
      for (int i = 0; i < NUM_DATA; i++) begin
         if (rd_hit[i]) rd_data = data_q[i];
      end
   end

endmodule

// File: rtl/aux_edid_responder_chk.sv
module aux_edid_responder_chk #(
   parameter int unsigned EDID_BYTES = 128,
   parameter int unsigned PTR_W      = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [7:0]       wr_ofs,
   input logic [31:0]      wr_data,
   input logic [31:0]      ctrl_q,
   input logic [31:0]      data_w0,
   input logic [31:0]      data_w1,
   input logic             sess_sel,
   input logic [PTR_W-1:0] edid_ptr
);
   logic       ctl_wr;
   logic       snd;
   logic [4:0] len;
   logic       bad_rd;

   assign ctl_wr = wr_en && (wr_ofs == 8'h10);
   assign snd    = ctl_wr && wr_data[31];
   assign len    = wr_data[24:20];
   assign bad_rd = data_w0[28] && (len != 5'd3) && (len != 5'd4);

   assert_idle_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !wr_data[31]) |=> ($stable(ctrl_q) && $stable(data_w0)));

   assert_done_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      snd |=> (ctrl_q[30] && !ctrl_q[31] &&
               ctrl_q[24:20] == ($past(data_w0[28]) ? 5'd2 : 5'd1)));

   assert_ack_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snd && !bad_rd) |=> (data_w0[31:24] == 8'h00));

   assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (snd && len == 5'd3 && !data_w0[30]) |=> (!sess_sel && edid_ptr == '0));

   assert_ptr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(edid_ptr) <= EDID_BYTES));

   assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (edid_ptr != $past(edid_ptr)) |-> (edid_ptr == '0 || edid_ptr == $past(edid_ptr) + 1'b1));

   assert_data_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ofs == 8'h18) |=> (data_w1 == $past(wr_data)));

endmodule

bind aux_edid_responder aux_edid_responder_chk #(
   .EDID_BYTES (EDID_BYTES),
   .PTR_W      (PTR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_ofs   (wr_addr[7:0]),
   .wr_data  (wr_data),
   .ctrl_q   (ctrl_q),
   .data_w0  (data_q[0]),
   .data_w1  (data_q[1]),
   .sess_sel (sess_sel),
   .edid_ptr (edid_ptr)
);

// File: tb/aux_edid_responder_tb.sv
module aux_edid_responder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [1:0]  chan_port = 2'd1;
   logic [3:0]  dp_present = 4'b0010;
   logic [6:0]  edid_rd_addr;
   logic [7:0]  edid_rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // bench model
   logic [31:0] m_ctrl;
   logic [31:0] m_data [5];
   logic        m_sel;
   logic        m_avail;
   int          m_ptr;

   always #5 clk = ~clk;

   function automatic logic [7:0] edid_fn(input logic [6:0] a);
      logic [15:0] p;
      p = 16'(a) * 16'd37;
      return p[7:0] ^ 8'hA5;
   endfunction

   assign edid_rd_data = edid_fn(edid_rd_addr);

   aux_edid_responder u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .rd_addr      (rd_addr),
      .rd_data      (rd_data),
      .chan_port    (chan_port),
      .dp_present   (dp_present),
      .edid_rd_addr (edid_rd_addr),
      .edid_rd_data (edid_rd_data)
   );

   task automatic m_clear();
      m_sel = 1'b0; m_avail = 1'b0; m_ptr = 0;
   endtask

   task automatic m_apply(input logic [7:0] a, input logic [31:0] d);
      logic [4:0]  ln;
      logic        rd;
      logic        mot;
      logic [15:0] ad;
      logic [7:0]  b;
      if (a >= 8'h14 && a <= 8'h24 && a[1:0] == 2'b00) begin
         m_data[int'((a - 8'h14) >> 2)] = d;
      end else if (a == 8'h10 && d[31]) begin
         ln  = d[24:20];
         rd  = m_data[0][28];
         mot = m_data[0][30];
         ad  = m_data[0][23:8];
         m_ctrl = 32'h4000_0000 | ((rd ? 32'd2 : 32'd1) << 20);
         if (ln == 5'd3) begin
            if (!mot || ad == 16'h0) m_clear();
            else if (ad == 16'h0050) begin
               m_sel = 1'b1; m_avail = dp_present[chan_port];
            end
            m_data[0] = 32'h0;
         end else if (!rd) begin
            m_data[0] = 32'h0;
         end else if (ln == 5'd4) begin
            if (m_sel && m_avail) begin
               if (m_ptr < 128) begin
                  b = edid_fn(7'(m_ptr)); m_ptr++;
               end else b = 8'h00;
            end else b = 8'hFF;
            m_data[0] = {8'h00, b, 16'h0000};
         end
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      m_apply(a, d);
   endtask

   task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      rd_addr = a;
      #1;
      n_chk++;
      if (rd_data !== exp) begin
         n_fail++;
         $display("FAIL %s: offset 0x%0h got %h expected %h", tag, a, rd_data, exp);
      end
   endtask

   task automatic send_req(input logic [3:0] cmd, input logic [15:0] ad,
                           input logic [4:0] ln, input string tag);
      do_wr(8'h14, {cmd, 4'h0, ad, 8'h00});
      do_wr(8'h10, 32'h8000_0000 | (32'(ln) << 20));
      chk(8'h10, m_ctrl, tag);
      chk(8'h14, m_data[0], tag);
   endtask

   task automatic chk_all(input string tag);
      chk(8'h10, m_ctrl, tag);
      for (int i = 0; i < 5; i++) chk(8'(8'h14 + 4 * i), m_data[i], tag);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] hdr;
      void'($urandom(32'd4242));
      m_ctrl = '0;
      for (int i = 0; i < 5; i++) m_data[i] = '0;
      m_clear();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      chk_all("R12 reset");
      chk(8'h30, 32'h0, "R1 unmapped read");

      // R1 data stores and unmapped drop
      do_wr(8'h20, 32'hDEAD_BEEF);
      do_wr(8'h30, 32'h1234_5678);
      chk_all("R1 store");
      chk(8'h30, 32'h0, "R1 unmapped write");

      // R2 idle control write
      do_wr(8'h10, 32'h7FFF_FFFF);
      chk_all("R2 idle ctrl");

      // R9 read without session
      send_req(4'h1, 16'h0050, 5'd4, "R9 no target");

      // R6 select on port with monitor; R8 reads
      send_req(4'h5, 16'h0050, 5'd3, "R6 start");
      send_req(4'h5, 16'h0050, 5'd4, "R8 read0");
      send_req(4'h5, 16'h0050, 5'd4, "R8 read1");
      // R6 restart keeps pointer
      send_req(4'h5, 16'h0050, 5'd3, "R6 restart");
      send_req(4'h5, 16'h0050, 5'd4, "R6 restart read");
      // R11 malformed read length
      send_req(4'h5, 16'h0050, 5'd6, "R11 bad len");
      // R7 write request discarded
      send_req(4'h4, 16'h0050, 5'd8, "R7 write");
      // R5 address-zero reset
      send_req(4'h4, 16'h0000, 5'd3, "R5 addr zero");
      send_req(4'h5, 16'h0050, 5'd4, "R5 read after reset");
      // R6 port without monitor
      chan_port = 2'd2;
      send_req(4'h5, 16'h0050, 5'd3, "R6 no monitor");
      send_req(4'h5, 16'h0050, 5'd4, "R9 unavailable");
      // R4 stop
      chan_port = 2'd1;
      send_req(4'h5, 16'h0050, 5'd3, "R4 pre");
      send_req(4'h1, 16'h0050, 5'd3, "R4 stop");
      send_req(4'h1, 16'h0050, 5'd4, "R4 read after stop");

      // same-cycle: read data word 1 while the send rewrites it (R8)
      send_req(4'h5, 16'h0050, 5'd3, "R8 pre same-cycle");
      hdr = {4'h5, 4'h0, 16'h0050, 8'h00};
      do_wr(8'h14, hdr);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h10; wr_data = 32'h8040_0000;
      chk(8'h14, hdr, "R8 same-cycle old header");
      @(negedge clk);
      wr_en = 1'b0;
      m_apply(8'h10, 32'h8040_0000);
      chk(8'h14, m_data[0], "R8 same-cycle reply");

      // R10 run past the end of the store
      send_req(4'h5, 16'h0000, 5'd3, "R10 reset");
      send_req(4'h5, 16'h0050, 5'd3, "R10 start");
      for (int i = 0; i < 131; i++) send_req(4'h5, 16'h0050, 5'd4, "R10 sweep");

      // random mix
      for (int it = 0; it < 600; it++) begin
         int op;
         op = int'($urandom_range(0, 8));
         case (op)
            0: do_wr(8'(8'h14 + 4 * $urandom_range(1, 5)), $urandom());
            1: do_wr(8'h10, $urandom() & 32'h7FFF_FFFF);
            2: send_req(4'h5, 16'h0050, 5'd3, "R6 rand start");
            3: send_req(4'h5, 16'h0050, 5'd4, "R8 rand read");
            4: send_req(4'h1, 16'h0050, 5'd3, "R4 rand stop");
            5: send_req(4'h4, 16'h0000, 5'd3, "R5 rand addr0");
            6: send_req(4'h4, 16'($urandom()), 5'($urandom_range(5, 16)), "R7 rand write");
            7: send_req(4'h1, 16'h0050, (($urandom() & 1) != 0) ? 5'd2 : 5'd9, "R11 rand bad");
            default: begin
               dp_present = 4'($urandom());
               chan_port  = 2'($urandom());
            end
         endcase
         if (op < 2) chk_all("R1 R2 rand");
      end
      chk_all("R1 final");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule